// File: doc/BRIEF.md
# Processor System-Control Unit (Reset, Halt, Bus Fault)

This unit sits in the bus interface of a 16-bit processor. It watches three system-control lines: the reset line, the halt line and a bus-fault input. From them it decides whether the processor is being initialized, whether the bus must go quiet, whether a faulted bus cycle is re-run, and whether a bus-fault exception is raised. It also drives the reset line outward when a software reset is executed. It drives the halt line outward once the processor has given up after a double bus fault. It latches the data-bus width (8 or 16 bit) while reset is in force.

The reset and halt lines are bidirectional on a real board. Here each one is split into a sensed input, a driven value and a drive enable. The instruction engine, the exception fetch and the bus sequencer are outside the block. They talk to it through a few handshake signals: a bus cycle is in progress or is ending, a software reset is requested, exception handling is complete. The block returns run and output-enable permissions plus a retry pulse.

All control lines in this model are active high. `rst` is the power-on synchronous reset of the logic itself.

Top module: `sysctl_top`

## Requirements
- R1: When `rst_line_in` and `halt_line_in` are both high at a clock edge (and the block is not driving reset), `cpu_init` is high from that edge on. It stays high until SETTLE_CLKS (2) edges after the last such edge. Throughout initialization `run_en` and `bus_oe` are 0, and they become 1 one edge after `cpu_init` falls.
- R2: `bus_16bit` follows `width_sel` (1 = 16-bit, 0 = 8-bit) at every edge while `cpu_init` is high, including the two settle edges after reset is released. Afterwards it holds its value whatever `width_sel` does.
- R3: A `sw_reset_req` seen at an edge while `cpu_init` is 0 sets `rst_line_oe` and `rst_line_out` to 1 for exactly PULSE_CLKS (124) cycles. A request made while the pulse is running neither extends nor restarts it. The pulse changes neither `bus_16bit` nor `run_en`.
- R4: While `rst_line_oe` is 1, `rst_line_in` together with `halt_line_in` does not start initialization.
- R5: Halt raised while a bus cycle is in progress (`cyc_active`) drops `run_en` at once and keeps `bus_oe` at 1 until the edge where `cyc_done` is seen. After that edge both are 0. Halt raised with no cycle in progress turns both off at the next edge. Releasing halt turns both back on at the next edge.
- R6: A bus fault seen together with halt raises no exception. The bus stays off while halt is held. `retry_go` is high for exactly one cycle after the edge at which halt is seen released, and `run_en` returns at that same edge.
- R7: A bus fault without halt sets `exc_req` at the next edge and holds it, with `run_en` 1, until `exc_done` is seen. It then clears at the next edge.
- R8: A bus fault while `exc_req` is 1 is a double fault. `halt_line_oe` and `halt_line_out` go to 1 and `run_en`, `bus_oe` and `exc_req` go to 0. The block stays in this state, ignoring `exc_done`, bus faults and halt, until a full reset as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_line_in | input | 1 | Sensed level of the reset line |
| rst_line_out | output | 1 | Value driven onto the reset line |
| rst_line_oe | output | 1 | Drive enable of the reset line |
| halt_line_in | input | 1 | Sensed level of the halt line |
| halt_line_out | output | 1 | Value driven onto the halt line |
| halt_line_oe | output | 1 | Drive enable of the halt line |
| berr_in | input | 1 | Bus-fault indication for the current cycle |
| width_sel | input | 1 | Bus-width strap, 1 = 16-bit, 0 = 8-bit |
| sw_reset_req | input | 1 | Software reset instruction executed |
| cyc_active | input | 1 | A bus cycle is in progress |
| cyc_done | input | 1 | The current bus cycle completes this clock |
| exc_done | input | 1 | Bus-fault exception handling finished |
| cpu_init | output | 1 | Processor initialization in force |
| bus_16bit | output | 1 | Latched bus width, 1 = 16-bit |
| run_en | output | 1 | Sequencer may start bus cycles |
| bus_oe | output | 1 | Control outputs active, three-state outputs driven |
| retry_go | output | 1 | One-cycle pulse: re-run the faulted cycle |
| exc_req | output | 1 | Bus-fault exception request |

## Verification
The bench targets the settle window after reset release. A design that froze the width strap at release time would report the wrong width, and one that dropped `cpu_init` early would enable the bus too soon. It counts the software reset pulse to the exact cycle and raises a second request in mid-pulse, which exposes off-by-one counters and restartable pulses. It asserts reset with halt during that pulse to catch a block that reinitializes itself from its own output. It also checks a halt that arrives in mid-cycle, which must not cut the bus before `cyc_done`. Finally it checks the paths after a fault: retry without an exception, a retry pulse that must wait for halt release, and a double fault that must survive `exc_done` and clear only on a full reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [2:0] {
    BS_INIT   = 3'd0,
    BS_RUN    = 3'd1,
    BS_DRAIN  = 3'd2,
    BS_STOP   = 3'd3,
    BS_RETRY  = 3'd4,
    BS_EXC    = 3'd5,
    BS_DFAULT = 3'd6
  } bstate_t;

  function automatic logic st_runs(input bstate_t s);
    return (s == BS_RUN) || (s == BS_EXC);
  endfunction

  function automatic logic st_drives(input bstate_t s);
    return (s == BS_RUN) || (s == BS_EXC) || (s == BS_DRAIN);
  endfunction

endpackage

// File: rtl/sysctl_init.sv
module sysctl_init #(
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_line_in,
  input  logic halt_line_in,
  input  logic own_rst_drv,
  input  logic width_sel,
  output logic init_q,
  output logic mode16_q
);
  localparam int TW = $clog2(SETTLE_CLKS + 1);

  logic [TW-1:0] tail_q;
  logic          full_rst;

  // external reset counts only when paired with halt and not self-driven
  assign full_rst = rst_line_in && halt_line_in && !own_rst_drv;

  always_ff @(posedge clk) begin
    if (rst || full_rst) begin
      init_q   <= 1'b1;
      tail_q   <= TW'(SETTLE_CLKS);
      mode16_q <= width_sel;
    end else if (init_q) begin
      mode16_q <= width_sel;
      if (tail_q <= TW'(1)) begin
        init_q <= 1'b0;
        tail_q <= '0;
      end else begin
        tail_q <= tail_q - TW'(1);
      end
    end
  end

  AST_INIT_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    full_rst |=> init_q); // R1
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!init_q && !full_rst) |=> $stable(mode16_q)); // R2
  AST_OWN_RESET_MASK: assert property (@(posedge clk) disable iff (rst)
    (own_rst_drv && !init_q) |=> !init_q); // R4

endmodule

// File: rtl/sysctl_swrst.sv
module sysctl_swrst #(
  parameter int PULSE_CLKS = 124
) (
  input  logic clk,
  input  logic rst,
  input  logic init_q,
  input  logic req,
  output logic drv_q
);
  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   span_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
      cnt_q <= '0;
    end else if (drv_q) begin
      if (cnt_q == '0) drv_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end else if (req && !init_q) begin
      drv_q <= 1'b1;
      cnt_q <= CW'(PULSE_CLKS - 1);
    end
  end

  // independent length tracker for the checker
  always_ff @(posedge clk) begin
    if (rst)        span_q <= '0;
    else if (drv_q) span_q <= span_q + (CW+1)'(1);
    else            span_q <= '0;
  end

  AST_SWRST_START: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q) |-> $past(req && !init_q)); // R3
  AST_SWRST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q) |-> (span_q == (CW+1)'(PULSE_CLKS))); // R3

endmodule

// File: rtl/sysctl_bus.sv
module sysctl_bus
  import sysctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init_q,
  input  logic halt_in,
  input  logic berr_in,
  input  logic cyc_active,
  input  logic cyc_done,
  input  logic exc_done,
  output logic run_en,
  output logic bus_oe,
  output logic retry_go,
  output logic exc_req,
  output logic halt_drv
);
  bstate_t st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    if (init_q) begin
      st_nx = BS_INIT;
    end else begin
      unique case (st_q)
        BS_INIT: st_nx = BS_RUN;
        BS_RUN, BS_DRAIN: begin
          if (berr_in && halt_in)       st_nx = BS_RETRY;
          else if (berr_in)             st_nx = BS_EXC;
          else if (st_q == BS_DRAIN) begin
            if (cyc_done)               st_nx = halt_in ? BS_STOP : BS_RUN;
          end else if (halt_in) begin
            st_nx = (cyc_active && !cyc_done) ? BS_DRAIN : BS_STOP;
          end
        end
        BS_STOP:  if (!halt_in) st_nx = BS_RUN;
        BS_RETRY: if (!halt_in) st_nx = BS_RUN;
        BS_EXC: begin
          if (berr_in)       st_nx = BS_DFAULT;
          else if (exc_done) st_nx = BS_RUN;
        end
        BS_DFAULT: st_nx = BS_DFAULT;
        default:   st_nx = BS_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= BS_INIT;
      run_en   <= 1'b0;
      bus_oe   <= 1'b0;
      retry_go <= 1'b0;
      exc_req  <= 1'b0;
      halt_drv <= 1'b0;
    end else begin
      st_q     <= st_nx;
      run_en   <= st_runs(st_nx);
      bus_oe   <= st_drives(st_nx);
      retry_go <= (st_q == BS_RETRY) && (st_nx == BS_RUN);
      exc_req  <= (st_nx == BS_EXC);
      halt_drv <= (st_nx == BS_DFAULT);
    end
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_q |=> (!run_en && !bus_oe)); // R1
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == BS_STOP) |-> (!run_en && !bus_oe)); // R5
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == BS_DRAIN && !cyc_done && !berr_in && !init_q) |=> bus_oe); // R5
  AST_RETRY_GATED: assert property (@(posedge clk) disable iff (rst)
    retry_go |-> !$past(halt_in)); // R6
  AST_EXC_NO_HALT: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_req) |-> $past(berr_in && !halt_in)); // R7
  AST_DFAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (halt_drv && !init_q) |=> halt_drv); // R8

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top #(
  parameter int PULSE_CLKS  = 124,
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_line_in,
  output logic rst_line_out,
  output logic rst_line_oe,
  input  logic halt_line_in,
  output logic halt_line_out,
  output logic halt_line_oe,
  input  logic berr_in,
  input  logic width_sel,
  input  logic sw_reset_req,
  input  logic cyc_active,
  input  logic cyc_done,
  input  logic exc_done,
  output logic cpu_init,
  output logic bus_16bit,
  output logic run_en,
  output logic bus_oe,
  output logic retry_go,
  output logic exc_req
);
  logic init_q;
  logic own_drv;
  logic halt_drv;

  sysctl_init #(.SETTLE_CLKS(SETTLE_CLKS)) u_init (
    .clk          (clk),
    .rst          (rst),
    .rst_line_in  (rst_line_in),
    .halt_line_in (halt_line_in),
    .own_rst_drv  (own_drv),
    .width_sel    (width_sel),
    .init_q       (init_q),
    .mode16_q     (bus_16bit)
  );

  sysctl_swrst #(.PULSE_CLKS(PULSE_CLKS)) u_swrst (
    .clk    (clk),
    .rst    (rst),
    .init_q (init_q),
    .req    (sw_reset_req),
    .drv_q  (own_drv)
  );

  sysctl_bus u_bus (
    .clk        (clk),
    .rst        (rst),
    .init_q     (init_q),
    .halt_in    (halt_line_in),
    .berr_in    (berr_in),
    .cyc_active (cyc_active),
    .cyc_done   (cyc_done),
    .exc_done   (exc_done),
    .run_en     (run_en),
    .bus_oe     (bus_oe),
    .retry_go   (retry_go),
    .exc_req    (exc_req),
    .halt_drv   (halt_drv)
  );

  assign cpu_init      = init_q;
  assign rst_line_oe   = own_drv;
  assign rst_line_out  = own_drv;
  assign halt_line_oe  = halt_drv;
  assign halt_line_out = halt_drv;

endmodule

// File: tb/tb_sysctl_top.sv
module tb_sysctl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_line_in = 0, halt_line_in = 0, berr_in = 0, width_sel = 1;
  logic sw_reset_req = 0, cyc_active = 0, cyc_done = 0, exc_done = 0;
  logic rst_line_out, rst_line_oe, halt_line_out, halt_line_oe;
  logic cpu_init, bus_16bit, run_en, bus_oe, retry_go, exc_req;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sysctl_top dut (
    .clk(clk), .rst(rst),
    .rst_line_in(rst_line_in), .rst_line_out(rst_line_out), .rst_line_oe(rst_line_oe),
    .halt_line_in(halt_line_in), .halt_line_out(halt_line_out), .halt_line_oe(halt_line_oe),
    .berr_in(berr_in), .width_sel(width_sel), .sw_reset_req(sw_reset_req),
    .cyc_active(cyc_active), .cyc_done(cyc_done), .exc_done(exc_done),
    .cpu_init(cpu_init), .bus_16bit(bus_16bit), .run_en(run_en), .bus_oe(bus_oe),
    .retry_go(retry_go), .exc_req(exc_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_power_reset();
    width_sel = 1'b1;
    step(3);
    chk("R1", "init during power reset", cpu_init, 1);
    chk("R1", "run_en during power reset", run_en, 0);
    rst = 1'b0;
    step(1);
    chk("R1", "init first settle clock", cpu_init, 1);
    step(1);
    chk("R1", "init after settle", cpu_init, 0);
    chk("R2", "16-bit strap latched", bus_16bit, 1);
    chk("R1", "bus_oe still off", bus_oe, 0);
    step(1);
    chk("R1", "run_en after init", run_en, 1);
    chk("R1", "bus_oe after init", bus_oe, 1);
    chk("R1", "no reset drive", rst_line_oe, 0);
  endtask

  task automatic t_ext_init();
    rst_line_in = 1; halt_line_in = 1;
    step(1);
    chk("R1", "init on reset+halt", cpu_init, 1);
    chk("R1", "run_en off", run_en, 0);
    step(3);
    width_sel = 1'b0;
    rst_line_in = 0; halt_line_in = 0;
    step(1);
    chk("R1", "init held settle", cpu_init, 1);
    step(1);
    chk("R1", "init released", cpu_init, 0);
    chk("R2", "8-bit strap sampled in settle", bus_16bit, 0);
    step(1);
    chk("R1", "run_en back", run_en, 1);
  endtask

  task automatic t_mode_frozen();
    width_sel = 1'b1;
    step(5);
    chk("R2", "strap change after init ignored", bus_16bit, 0);
  endtask

  task automatic t_sw_reset();
    int len = 0;
    sw_reset_req = 1;
    step(1);
    sw_reset_req = 0;
    chk("R3", "reset drive starts", rst_line_oe, 1);
    chk("R3", "reset value", rst_line_out, 1);
    len = 1;
    for (int i = 0; i < 400; i++) begin
      if (len == 20) begin rst_line_in = 1; halt_line_in = 1; end
      if (len == 22) begin
        chk("R4", "own reset masks init", cpu_init, 0);
        rst_line_in = 0; halt_line_in = 0;
      end
      if (len == 50) sw_reset_req = 1;
      if (len == 51) sw_reset_req = 0;
      if (len == 60) begin
        chk("R3", "run_en kept during pulse", run_en, 1);
        chk("R3", "mode kept during pulse", bus_16bit, 0);
      end
      step(1);
      if (rst_line_oe) len++;
      else break;
    end
    chk("R3", "pulse length", len, 124);
    chk("R4", "no init after pulse", cpu_init, 0);
    step(1);
    chk("R3", "no restart", rst_line_oe, 0);
  endtask

  task automatic t_halt_drain();
    cyc_active = 1; halt_line_in = 1;
    step(1);
    chk("R5", "run_en drops on halt", run_en, 0);
    chk("R5", "bus kept while cycle runs", bus_oe, 1);
    step(2);
    chk("R5", "bus still kept", bus_oe, 1);
    cyc_done = 1;
    step(1);
    cyc_active = 0; cyc_done = 0;
    chk("R5", "bus off after cycle", bus_oe, 0);
    step(3);
    chk("R5", "stays stopped", bus_oe, 0);
    chk("R5", "no exception", exc_req, 0);
    halt_line_in = 0;
    step(1);
    chk("R5", "resume bus_oe", bus_oe, 1);
    chk("R5", "resume run_en", run_en, 1);
    chk("R5", "no retry on plain halt", retry_go, 0);
  endtask

  task automatic t_halt_idle();
    halt_line_in = 1;
    step(1);
    chk("R5", "idle halt stops bus", bus_oe, 0);
    halt_line_in = 0;
    step(1);
    chk("R5", "idle halt resume", bus_oe, 1);
  endtask

  task automatic t_retry();
    cyc_active = 1; berr_in = 1; halt_line_in = 1;
    step(1);
    berr_in = 0; cyc_active = 0;
    chk("R6", "no exception on fault+halt", exc_req, 0);
    chk("R6", "bus off while held", bus_oe, 0);
    step(3);
    chk("R6", "no early retry", retry_go, 0);
    halt_line_in = 0;
    step(1);
    chk("R6", "retry pulse", retry_go, 1);
    chk("R6", "run_en with retry", run_en, 1);
    step(1);
    chk("R6", "retry one cycle", retry_go, 0);
  endtask

  task automatic t_exception();
    berr_in = 1;
    step(1);
    berr_in = 0;
    chk("R7", "exception raised", exc_req, 1);
    chk("R7", "run_en in exception", run_en, 1);
    step(3);
    chk("R7", "exception held", exc_req, 1);
    exc_done = 1;
    step(1);
    exc_done = 0;
    chk("R7", "exception cleared", exc_req, 0);
  endtask

  task automatic t_double_fault();
    berr_in = 1;
    step(1);
    chk("R7", "first fault exception", exc_req, 1);
    step(1);
    berr_in = 0;
    chk("R8", "halt driven", halt_line_oe, 1);
    chk("R8", "halt value", halt_line_out, 1);
    chk("R8", "run_en off", run_en, 0);
    chk("R8", "bus off", bus_oe, 0);
    chk("R8", "exc_req off", exc_req, 0);
    exc_done = 1;
    step(1);
    exc_done = 0;
    step(3);
    chk("R8", "sticky after exc_done", halt_line_oe, 1);
    width_sel = 1;
    rst_line_in = 1; halt_line_in = 1;
    step(2);
    rst_line_in = 0; halt_line_in = 0;
    step(3);
    chk("R8", "cleared by full reset", halt_line_oe, 0);
    chk("R8", "run after full reset", run_en, 1);
    chk("R2", "16-bit relatched", bus_16bit, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_power_reset();
    t_ext_init();
    t_mode_frozen();
    t_sw_reset();
    t_halt_drain();
    t_halt_idle();
    t_retry();
    t_exception();
    t_double_fault();
    step(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule